// File: doc/BRIEF.md
# Weighted Activity Monitor with Recursive Averaging

This block watches a single activity event line and turns it into periodic load figures. A sample timer cuts time into windows of a programmable number of clock cycles. During each window every event adds a programmable weight to an accumulator. When the window closes, the weighted total is latched as the raw count. A first-order recursive (IIR) running average is updated with the new count, and both figures are compared with programmable thresholds.

Crossing a threshold on the raw count only counts once the crossing has held for a programmable number of back-to-back windows. The running average has its own pair of thresholds. Each of the four event kinds latches a sticky status bit that is set only while its own enable is on. The interrupt line is the OR of the pending bits whose enable is on. A global status word reports, at a fixed bit, that any status bit is pending. Everything is configured and observed through a plain single-cycle write/read register bus.

Top module: `act_mon`

## Requirements
- R1: Word addresses are 0 control, 1 period, 2 high threshold, 3 low threshold, 4 average preload, 5 average high threshold, 6 average low threshold, 7 weight, 8 raw count (read-only), 9 average (read-only), 10 status, 11 global status. After reset the control, status, count and average read 0, the period register reads PERIOD_RST-1 (15), the weight reads 0x200, and irq_o and the global status are 0.
- R2: Sampling runs only while control bit 31 (master enable) and bit 18 (periodic sampling) are both 1. Each window lasts period-register+1 cycles, counted from the first cycle after sampling starts. At the window's last edge the raw count becomes weight times the number of cycles in that window with event_i high. Inside a window the raw count keeps its previous value.
- R3: While bit 31 or bit 18 is 0, events are ignored, the count and the average hold, and the window timer and the accumulator restart from zero.
- R4: At every window end the average becomes avg + ((count - avg) >>> (K+1)), computed signed, with floor rounding on a negative difference. K is control bits 12:10.
- R5: Status bit 31 is set when the raw count has been strictly greater than the high threshold for N consecutive windows, and control bit 30 is 1. N is control bits 28:26 plus one. A window without the crossing resets the run of windows.
- R6: Status bit 30 is set when the raw count has been strictly less than the low threshold for N consecutive windows, and control bit 29 is 1. N is control bits 25:23 plus one. The run resets in the same way.
- R7: At a window end, status bit 24 is set when the new average is strictly greater than the average high threshold and control bit 21 is 1. Status bit 25 is set when the new average is strictly less than the average low threshold and control bit 20 is 1.
- R8: Status bits are sticky. Writing the status address clears exactly those of bits 31, 30, 25 and 24 that are written as 1, so a write of all ones clears them all.
- R9: irq_o is the OR of the pending status bits whose enables (bits 30, 29, 20, 21 for status 31, 30, 25, 24) are 1. Bit 26 of the global status is 1 whenever any status bit is pending, whatever the enables.
- R10: A write to the average preload address loads the running average directly. The loaded value reads back at address 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| event_i | input | 1 | Activity event, one weighted event per high cycle |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_o | output | 1 | Interrupt, OR of enabled pending status bits |
| glb_status_o | output | 32 | Global status word, bit 26 set when any status bit is pending |

## Verification
Weighted counting is tried with several event totals per window, including zero, and with a mid-window read. This separates a latch at the window end from a running update. The average is driven both upward and downward with two window lengths, so a wrong shift amount or wrong rounding of negative differences shows up in the read-back value. The raw-count thresholds get streaks that break one window short of the required length before they complete. This tells a consecutive-window counter from a cumulative one. Enable gating, partial and full status clears, and sampling with either run bit low show whether status, interrupt and global bit are kept apart.

// File: rtl/act_mon_pkg.sv
`timescale 1ns/1ps
package act_mon_pkg;
    // register word addresses
    localparam logic [3:0] A_CTRL    = 4'd0;
    localparam logic [3:0] A_PERIOD  = 4'd1;
    localparam logic [3:0] A_HI_WM   = 4'd2;
    localparam logic [3:0] A_LO_WM   = 4'd3;
    localparam logic [3:0] A_PRELOAD = 4'd4;
    localparam logic [3:0] A_AVG_HI  = 4'd5;
    localparam logic [3:0] A_AVG_LO  = 4'd6;
    localparam logic [3:0] A_WEIGHT  = 4'd7;
    localparam logic [3:0] A_COUNT   = 4'd8;
    localparam logic [3:0] A_AVG     = 4'd9;
    localparam logic [3:0] A_STATUS  = 4'd10;
    localparam logic [3:0] A_GLOBAL  = 4'd11;

    // control bit positions
    localparam int C_RUN    = 31;
    localparam int C_HI_EN  = 30;
    localparam int C_LO_EN  = 29;
    localparam int C_HI_N   = 26;   // 3-bit field base
    localparam int C_LO_N   = 23;   // 3-bit field base
    localparam int C_AHI_EN = 21;
    localparam int C_ALO_EN = 20;
    localparam int C_PERIOD = 18;
    localparam int C_K      = 10;   // 3-bit field base

    // status bit positions in the bus word
    localparam int S_HI  = 31;
    localparam int S_LO  = 30;
    localparam int S_ALO = 25;
    localparam int S_AHI = 24;

    // packed index inside the 4-bit internal status vector
    localparam int I_HI  = 3;
    localparam int I_LO  = 2;
    localparam int I_ALO = 1;
    localparam int I_AHI = 0;
endpackage

// File: rtl/act_mon_timer.sv
`timescale 1ns/1ps
module act_mon_timer #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [PW-1:0] limit_i,
    output logic          tick_o
);
    logic [PW-1:0] cnt_d, cnt_q;

    assign tick_o = run_i && (cnt_q == limit_i);

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/act_mon_accum.sv
`timescale 1ns/1ps
module act_mon_accum #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic          event_i,
    input  logic [DW-1:0] weight_i,
    output logic [DW-1:0] sample_o
);
    logic [DW-1:0] acc_d, acc_q;

    // total including the event of the current cycle
    assign sample_o = acc_q + (event_i ? weight_i : '0);

    always_comb begin
        acc_d = sample_o;
        if (!run_i || tick_i) begin
            acc_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/act_mon_iir.sv
`timescale 1ns/1ps
module act_mon_iir #(
    parameter int DW = 32,
    parameter int KW = 3
) (
    input  logic [DW-1:0] avg_i,
    input  logic [DW-1:0] sample_i,
    input  logic [KW-1:0] k_i,
    output logic [DW-1:0] avg_o
);
    localparam int XW = DW + 2;

    logic signed [XW-1:0] diff;
    logic signed [XW-1:0] step;
    logic signed [XW-1:0] sum;

    always_comb begin
        diff = $signed({2'b00, sample_i}) - $signed({2'b00, avg_i});
        step = diff >>> ({1'b0, k_i} + 1'b1);
        sum  = $signed({2'b00, avg_i}) + step;
        // the result lies between avg and sample; the clamp only guards range
        if (sum[XW-1])      avg_o = '0;
        else if (sum[DW])   avg_o = '1;
        else                avg_o = sum[DW-1:0];
    end
endmodule

// File: rtl/act_mon_streak.sv
`timescale 1ns/1ps
module act_mon_streak #(
    parameter int NW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic          cond_i,
    input  logic [NW-1:0] need_m1_i,
    output logic          hit_o
);
    localparam int RW = NW + 1;
    localparam logic [RW-1:0] RMAX = RW'(2 ** NW);

    logic [RW-1:0] run_d, run_q;

    assign hit_o = tick_i && cond_i && (run_q >= {1'b0, need_m1_i});

    always_comb begin
        run_d = run_q;
        if (!run_i) begin
            run_d = '0;
        end else if (tick_i) begin
            if (!cond_i)            run_d = '0;
            else if (run_q != RMAX) run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end
endmodule

// File: rtl/act_mon.sv
`timescale 1ns/1ps
module act_mon
    import act_mon_pkg::*;
#(
    parameter int          DW         = 32,
    parameter int          PW         = 16,
    parameter int          NW         = 3,
    parameter int          KW         = 3,
    parameter int          PERIOD_RST = 16,
    parameter logic [31:0] WEIGHT_RST = 32'h200,
    parameter int          GLB_BIT    = 26
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        event_i,
    input  logic        bus_wr_i,
    input  logic [3:0]  bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        irq_o,
    output logic [31:0] glb_status_o
);
    localparam logic [PW-1:0] PERIOD_INIT = PW'(PERIOD_RST - 1);

    typedef struct packed {
        logic [31:0]   ctrl;
        logic [PW-1:0] period;
        logic [DW-1:0] hi_wm;
        logic [DW-1:0] lo_wm;
        logic [DW-1:0] avg_hi;
        logic [DW-1:0] avg_lo;
        logic [DW-1:0] weight;
        logic [DW-1:0] count;
        logic [DW-1:0] avg;
        logic [3:0]    stat;
    } mon_state_t;

    mon_state_t st_d, st_q;

    logic          running, tick;
    logic [DW-1:0] sample, avg_nx;
    logic          hi_hit, lo_hit;
    logic          init_wr, stat_wr;
    logic [3:0]    set_v, clr_v, en_v;

    assign running = st_q.ctrl[C_RUN] && st_q.ctrl[C_PERIOD];
    assign init_wr = bus_wr_i && (bus_addr_i == A_PRELOAD);
    assign stat_wr = bus_wr_i && (bus_addr_i == A_STATUS);

    act_mon_timer #(.PW(PW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (running),
        .limit_i (st_q.period),
        .tick_o  (tick)
    );

    act_mon_accum #(.DW(DW)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (running),
        .tick_i   (tick),
        .event_i  (event_i),
        .weight_i (st_q.weight),
        .sample_o (sample)
    );

    act_mon_iir #(.DW(DW), .KW(KW)) u_iir (
        .avg_i    (st_q.avg),
        .sample_i (sample),
        .k_i      (st_q.ctrl[C_K +: KW]),
        .avg_o    (avg_nx)
    );

    // high and low raw-count streak detectors share one structure
    for (genvar g = 0; g < 2; g++) begin : g_streak
        logic cond;
        logic hit;
        assign cond = (g == 0) ? (sample > st_q.hi_wm) : (sample < st_q.lo_wm);
        act_mon_streak #(.NW(NW)) u_streak (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_i     (running),
            .tick_i    (tick),
            .cond_i    (cond),
            .need_m1_i ((g == 0) ? st_q.ctrl[C_HI_N +: NW] : st_q.ctrl[C_LO_N +: NW]),
            .hit_o     (hit)
        );
    end
    assign hi_hit = g_streak[0].hit;
    assign lo_hit = g_streak[1].hit;

    assign en_v[I_HI]  = st_q.ctrl[C_HI_EN];
    assign en_v[I_LO]  = st_q.ctrl[C_LO_EN];
    assign en_v[I_ALO] = st_q.ctrl[C_ALO_EN];
    assign en_v[I_AHI] = st_q.ctrl[C_AHI_EN];

    assign clr_v = stat_wr ? {bus_wdata_i[S_HI], bus_wdata_i[S_LO],
                              bus_wdata_i[S_ALO], bus_wdata_i[S_AHI]} : 4'b0000;

    always_comb begin
        set_v        = 4'b0000;
        set_v[I_HI]  = hi_hit;
        set_v[I_LO]  = lo_hit;
        set_v[I_ALO] = tick && (avg_nx < st_q.avg_lo);
        set_v[I_AHI] = tick && (avg_nx > st_q.avg_hi);
        set_v        = set_v & en_v;
    end

    always_comb begin
        st_d = st_q;
        if (bus_wr_i) begin
            case (bus_addr_i)
                A_CTRL:    st_d.ctrl   = bus_wdata_i;
                A_PERIOD:  st_d.period = bus_wdata_i[PW-1:0];
                A_HI_WM:   st_d.hi_wm  = bus_wdata_i[DW-1:0];
                A_LO_WM:   st_d.lo_wm  = bus_wdata_i[DW-1:0];
                A_AVG_HI:  st_d.avg_hi = bus_wdata_i[DW-1:0];
                A_AVG_LO:  st_d.avg_lo = bus_wdata_i[DW-1:0];
                A_WEIGHT:  st_d.weight = bus_wdata_i[DW-1:0];
                default: ;
            endcase
        end
        if (tick) begin
            st_d.count = sample;
            st_d.avg   = avg_nx;
        end
        if (init_wr) begin
            st_d.avg = bus_wdata_i[DW-1:0];
        end
        st_d.stat = (st_q.stat & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.period <= PERIOD_INIT;
            st_q.weight <= WEIGHT_RST[DW-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = |(st_q.stat & en_v);

    always_comb begin
        glb_status_o          = '0;
        glb_status_o[GLB_BIT] = |st_q.stat;
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_CTRL:    bus_rdata_o = st_q.ctrl;
            A_PERIOD:  bus_rdata_o[PW-1:0] = st_q.period;
            A_HI_WM:   bus_rdata_o[DW-1:0] = st_q.hi_wm;
            A_LO_WM:   bus_rdata_o[DW-1:0] = st_q.lo_wm;
            A_PRELOAD: bus_rdata_o[DW-1:0] = st_q.avg;
            A_AVG_HI:  bus_rdata_o[DW-1:0] = st_q.avg_hi;
            A_AVG_LO:  bus_rdata_o[DW-1:0] = st_q.avg_lo;
            A_WEIGHT:  bus_rdata_o[DW-1:0] = st_q.weight;
            A_COUNT:   bus_rdata_o[DW-1:0] = st_q.count;
            A_AVG:     bus_rdata_o[DW-1:0] = st_q.avg;
            A_STATUS: begin
                bus_rdata_o[S_HI]  = st_q.stat[I_HI];
                bus_rdata_o[S_LO]  = st_q.stat[I_LO];
                bus_rdata_o[S_ALO] = st_q.stat[I_ALO];
                bus_rdata_o[S_AHI] = st_q.stat[I_AHI];
            end
            A_GLOBAL:  bus_rdata_o = glb_status_o;
            default: ;
        endcase
    end
endmodule

// File: rtl/act_mon_chk.sv
`timescale 1ns/1ps
module act_mon_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          running,
    input logic          tick,
    input logic          init_wr,
    input logic          stat_wr,
    input logic [31:0]   ctrl,
    input logic [3:0]    stat,
    input logic [DW-1:0] count,
    input logic [DW-1:0] avg,
    input logic          irq_o,
    input logic [31:0]   glb_status_o
);
    // R9: an interrupt needs a pending bit in the global word
    p_irq_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> glb_status_o[26]);

    // R3: no sampling while stopped
    p_idle_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> $stable(count));

    // R4: the new average lies between the old average and the new count
    p_avg_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tick) && !$past(init_wr)) |->
        (((avg >= $past(avg)) && (avg <= count)) ||
         ((avg <= $past(avg)) && (avg >= count))));

    // R5 / R6 / R7: a status bit rises only with its enable set
    p_hi_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[3]) |-> $past(ctrl[30]));
    p_lo_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[2]) |-> $past(ctrl[29]));
    p_avg_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stat[0]) |-> $past(ctrl[21])) and ($rose(stat[1]) |-> $past(ctrl[20])));

    // R8: a pending bit stays unless the status address is written
    for (genvar i = 0; i < 4; i++) begin : g_sticky
        p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(stat[i]) && !$past(stat_wr)) |-> stat[i]);
    end
endmodule

bind act_mon act_mon_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .running      (running),
    .tick         (tick),
    .init_wr      (init_wr),
    .stat_wr      (stat_wr),
    .ctrl         (st_q.ctrl),
    .stat         (st_q.stat),
    .count        (st_q.count),
    .avg          (st_q.avg),
    .irq_o        (irq_o),
    .glb_status_o (glb_status_o)
);

// File: tb/act_mon_bench.sv
`timescale 1ns/1ps
module act_mon_bench;
    localparam logic [31:0] EN  = 32'h8000_0000;
    localparam logic [31:0] HIE = 32'h4000_0000;
    localparam logic [31:0] LOE = 32'h2000_0000;
    localparam logic [31:0] AHE = 32'h0020_0000;
    localparam logic [31:0] ALE = 32'h0010_0000;
    localparam logic [31:0] PER = 32'h0004_0000;
    localparam logic [31:0] ST_HI  = 32'h8000_0000;
    localparam logic [31:0] ST_LO  = 32'h4000_0000;
    localparam logic [31:0] ST_ALO = 32'h0200_0000;
    localparam logic [31:0] ST_AHI = 32'h0100_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        event_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [3:0]  bus_addr_i = 4'd0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        irq_o;
    logic [31:0] glb_status_o;

    int tests = 0;
    int fails = 0;
    int plen  = 4;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    act_mon u_act_mon (
        .clk          (clk),
        .rst_n        (rst_n),
        .event_i      (event_i),
        .bus_wr_i     (bus_wr_i),
        .bus_addr_i   (bus_addr_i),
        .bus_wdata_i  (bus_wdata_i),
        .bus_rdata_o  (bus_rdata_o),
        .irq_o        (irq_o),
        .glb_status_o (glb_status_o)
    );

    task automatic check(input string tag, input longint got, input longint exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, got, got, exp, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr_i = a;
        #1;
        d = bus_rdata_o;
    endtask

    task automatic step(input bit ev);
        event_i = ev;
        @(negedge clk);
        event_i = 1'b0;
    endtask

    task automatic run_period(input int n);
        for (int i = 0; i < plen; i++) step(i < n);
    endtask

    function automatic longint iir(input longint a, input longint c, input int k);
        return a + ((c - a) >>> (k + 1));
    endfunction

    // stop, program period/weight/preload, clear status
    task automatic setup(input int p, input logic [31:0] w, input logic [31:0] init);
        wr(4'd0, 32'h0);
        wr(4'd1, p - 1);
        plen = p;
        wr(4'd7, w);
        wr(4'd4, init);
        wr(4'd10, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'd0, d);  check("R1 ctrl reset", d, 0);
        rd(4'd1, d);  check("R1 period reset", d, 15);
        rd(4'd7, d);  check("R1 weight reset", d, 32'h200);
        rd(4'd10, d); check("R1 status reset", d, 0);
        rd(4'd8, d);  check("R1 count reset", d, 0);
        check("R1 irq reset", irq_o, 0);
        check("R1 global reset", glb_status_o, 0);
    endtask

    task automatic t_count();
        logic [31:0] d;
        longint a = 100;
        setup(4, 5, 100);
        wr(4'd0, EN | PER | (32'd1 << 10));
        run_period(2);
        a = iir(a, 10, 1);
        rd(4'd8, d); check("R2 count 2 events", d, 10);
        rd(4'd9, d); check("R4 avg down K=1", d, a);
        step(1); step(1);
        rd(4'd8, d); check("R2 count holds mid window", d, 10);
        step(1); step(1);
        a = iir(a, 20, 1);
        rd(4'd8, d); check("R2 count 4 events", d, 20);
        rd(4'd9, d); check("R4 avg second window", d, a);
        run_period(0);
        a = iir(a, 0, 1);
        rd(4'd8, d); check("R2 count zero events", d, 0);
        rd(4'd9, d); check("R4 avg negative floor", d, a);
    endtask

    task automatic t_iir();
        logic [31:0] d;
        longint a = 3;
        setup(8, 16, 3);
        wr(4'd0, EN | PER);
        run_period(7);
        a = iir(a, 112, 0);
        rd(4'd9, d); check("R4 avg up K=0", d, a);
        run_period(1);
        a = iir(a, 16, 0);
        rd(4'd9, d); check("R4 avg down K=0", d, a);
        wr(4'd0, 0);
        wr(4'd4, 1234);
        rd(4'd9, d); check("R10 preload reads back", d, 1234);
    endtask

    task automatic t_stop();
        logic [31:0] d;
        setup(4, 1, 0);
        wr(4'd0, EN | PER);
        run_period(3);
        rd(4'd8, d); check("R2 count weight 1", d, 3);
        wr(4'd0, PER);
        for (int i = 0; i < 10; i++) step(1);
        rd(4'd8, d); check("R3 count hold, enable low", d, 3);
        rd(4'd9, d); check("R3 avg hold, enable low", d, 1);
        wr(4'd0, EN);
        for (int i = 0; i < 10; i++) step(1);
        rd(4'd8, d); check("R3 count hold, periodic low", d, 3);
        wr(4'd0, EN | PER);
        run_period(2);
        rd(4'd8, d); check("R3 restart from zero", d, 2);
    endtask

    task automatic t_hi();
        logic [31:0] d;
        setup(4, 1, 0);
        wr(4'd2, 3);
        wr(4'd0, EN | PER | HIE | (32'd1 << 26));
        run_period(4); run_period(2); run_period(4);
        rd(4'd10, d); check("R5 broken streak no event", d, 0);
        run_period(4);
        rd(4'd10, d); check("R5 two windows above sets bit 31", d, ST_HI);
        setup(4, 1, 0);
        wr(4'd0, EN | PER);
        run_period(4);
        rd(4'd10, d); check("R5 disabled high no event", d, 0);
    endtask

    task automatic t_lo();
        logic [31:0] d;
        setup(4, 1, 0);
        wr(4'd3, 2);
        wr(4'd0, EN | PER | LOE | (32'd2 << 23));
        run_period(1); run_period(1); run_period(3); run_period(1); run_period(1);
        rd(4'd10, d); check("R6 two of three windows no event", d, 0);
        run_period(1);
        rd(4'd10, d); check("R6 three windows below sets bit 30", d, ST_LO);
    endtask

    task automatic t_avg();
        logic [31:0] d;
        setup(16, 4, 40);
        wr(4'd5, 45);
        wr(4'd6, 30);
        wr(4'd0, EN | PER | AHE);
        run_period(16);
        rd(4'd9, d);  check("R4 avg 64 from 40", d, 52);
        rd(4'd10, d); check("R7 avg above sets bit 24", d, ST_AHI);
        run_period(0);
        rd(4'd10, d); check("R7 avg below, low disabled", d, ST_AHI);
        wr(4'd0, 0);
        wr(4'd10, 32'hFFFF_FFFF);
        wr(4'd0, EN | PER | ALE);
        run_period(0);
        rd(4'd9, d);  check("R4 avg 0 from 26", d, 13);
        rd(4'd10, d); check("R7 avg below sets bit 25", d, ST_ALO);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        setup(4, 1, 10);
        wr(4'd5, 5);
        wr(4'd0, EN | PER | AHE);
        run_period(4);
        rd(4'd10, d); check("R7 avg 7 above 5", d, ST_AHI);
        check("R9 irq with enabled pending", irq_o, 1);
        run_period(0);
        rd(4'd10, d); check("R8 sticky after avg falls", d, ST_AHI);
        wr(4'd0, AHE);
        check("R9 irq stays while stopped", irq_o, 1);
        wr(4'd10, ST_HI);
        rd(4'd10, d); check("R8 partial clear keeps bit 24", d, ST_AHI);
        wr(4'd0, 0);
        check("R9 irq off with enable off", irq_o, 0);
        check("R9 global bit still set", glb_status_o, 32'h0400_0000);
        rd(4'd11, d); check("R9 global via bus", d, 32'h0400_0000);
        wr(4'd10, 32'hFFFF_FFFF);
        rd(4'd10, d); check("R8 all ones clears", d, 0);
        check("R9 global clear", glb_status_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_iir();
        t_stop();
        t_hi();
        t_lo();
        t_avg();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule